// File: doc/BRIEF.md
# Stateful NOR Crossbar Array Model

This block is a cycle-level digital model of a small resistive crossbar that computes inside its own storage. Every cell holds one bit. A stored one stands for the low-resistance device state and a stored zero for the high-resistance state. A command port accepts one operation per clock. The operations are NOR across a row, NOR down a column, single-input NOT, setting a whole row or column to one, and plain cell write and read.

Logic results never come from outside the array. A NOR or NOT reads its input cells, leaves them as they are, and can only pull its output cell from one down to zero. The new output value is the old value ANDed with the inverted OR of the inputs. An output cell must therefore be set to one before it is used. The block raises an error flag when a targeted output cell already holds zero. One row-NOR command evaluates every row chosen by a row mask, using the same input columns and the same output column in each row.

The whole array is visible on a flat state port. A compiler-produced command stream can be replayed against it and checked against the expected Boolean results.

Top module: `nor_xbar`

## Requirements
- R1: After reset every cell holds 1, `err` is 0, `rd_valid` is 0 and `rd_data` is 0. Cell (r,c) appears on `state` bit r*COLS+c.
- R2: With opcode 1 (row NOR), the cell at column `cmd_col` of every row r with `cmd_mask[r]` set becomes its old value AND NOT(OR of that row's cells at the columns set in `cmd_in_cols`). All selected rows do this in the same cycle.
- R3: With opcode 2 (column NOR), cell (`cmd_row`,`cmd_col`) becomes its old value AND NOT(OR of column `cmd_col` at the rows set in `cmd_in_rows`).
- R4: With opcode 3 (NOT), cell (`cmd_row`,`cmd_col`) becomes its old value AND NOT cell (`cmd_row`,`cmd_src`).
- R5: A logic operation (opcodes 1 to 3) changes no cell other than its output cells, and it never turns a 0 into a 1.
- R6: `err` is 1 in the cycle after a logic operation for which any output cell held 0 beforehand. Otherwise it is 0.
- R7: Opcode 4 sets every cell of row `cmd_row` to 1, and opcode 5 sets every cell of column `cmd_col` to 1. Each takes a single cycle.
- R8: Opcode 6 stores `cmd_wdata` into cell (`cmd_row`,`cmd_col`) and changes nothing else.
- R9: Opcode 7 leaves the array unchanged. In the next cycle it gives `rd_valid`=1 and puts the cell (`cmd_row`,`cmd_col`) value on `rd_data`. At all other times `rd_valid` is 0.
- R10: Opcode 0 changes no cell and raises neither `err` nor `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Opcode 0..7 |
| cmd_row | input | $clog2(ROWS) | Target row index |
| cmd_col | input | $clog2(COLS) | Target column index |
| cmd_src | input | $clog2(COLS) | Input column for NOT |
| cmd_in_cols | input | COLS | Input-column bitmap for row NOR |
| cmd_in_rows | input | ROWS | Input-row bitmap for column NOR |
| cmd_mask | input | ROWS | Rows evaluated by a row NOR |
| cmd_wdata | input | 1 | Write data |
| rd_data | output | 1 | Read result |
| rd_valid | output | 1 | Read result valid |
| err | output | 1 | Output cell was 0 before a logic operation |
| state | output | ROWS*COLS | Whole array, cell (r,c) at bit r*COLS+c |

## Verification
Row NOR is exercised with three input patterns. In the first, all inputs are zero, so the output keeps its one. In the second, a single input is one and pulls the output down. In the third, rows under a partial mask differ, which separates masked rows from unmasked ones and shows that rows are evaluated independently. Column NOR and NOT are driven with inputs taken from several rows and with both input polarities. The error tests aim a logic operation at an output cell that was cleared beforehand, and they also show that a correctly prepared cell raises no error. A long run of random commands is compared against a reference array after every cycle. This catches cross-talk between cells, wrong input selection and wrong index mapping.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_NORH = 3'd1,
    OP_NORV = 3'd2,
    OP_NOT  = 3'd3,
    OP_RROW = 3'd4,
    OP_RCOL = 3'd5,
    OP_WR   = 3'd6,
    OP_RD   = 3'd7
  } xbar_op_e;

  // stateful pull-down: an output may only move from 1 to 0
  function automatic logic pull_down(input logic cur, input logic any_one);
    return cur & ~any_one;
  endfunction

  function automatic logic is_logic_op(input xbar_op_e op);
    return (op == OP_NORH) || (op == OP_NORV) || (op == OP_NOT);
  endfunction
endpackage

// File: rtl/xbar_eval.sv
module xbar_eval
  import xbar_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic [ROWS*COLS-1:0] cells,
  input  xbar_op_e             op,
  input  logic [RW-1:0]        row,
  input  logic [CW-1:0]        col,
  input  logic [CW-1:0]        src,
  input  logic [COLS-1:0]      in_cols,
  input  logic [ROWS-1:0]      in_rows,
  input  logic [ROWS-1:0]      mask,
  input  logic                 wdata,
  output logic [ROWS*COLS-1:0] next_cells,
  output logic                 tgt_zero
);
  logic [COLS-1:0][ROWS-1:0] col_view;
  logic [ROWS-1:0]           h_any;
  logic                      v_any;
  logic                      n_in;
  logic                      tgt_cur;

  always_comb begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        col_view[c][r] = cells[r*COLS + c];
  end

  genvar gr;
  generate
    for (gr = 0; gr < ROWS; gr++) begin : g_row_any
      assign h_any[gr] = |(cells[gr*COLS +: COLS] & in_cols);
    end
  endgenerate

  assign v_any   = |(col_view[col] & in_rows);
  assign n_in    = cells[int'(row)*COLS + int'(src)];
  assign tgt_cur = cells[int'(row)*COLS + int'(col)];

  always_comb begin
    unique case (op)
      OP_NORH:        tgt_zero = |(mask & ~col_view[col]);
      OP_NORV, OP_NOT: tgt_zero = ~tgt_cur;
      default:        tgt_zero = 1'b0;
    endcase
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        logic cur, hit;
        cur = cells[r*COLS + c];
        hit = (r == int'(row)) && (c == int'(col));
        next_cells[r*COLS + c] = cur;
        unique case (op)
          OP_NORH: if (mask[r] && c == int'(col)) next_cells[r*COLS + c] = pull_down(cur, h_any[r]);
          OP_NORV: if (hit) next_cells[r*COLS + c] = pull_down(cur, v_any);
          OP_NOT:  if (hit) next_cells[r*COLS + c] = pull_down(cur, n_in);
          OP_RROW: if (r == int'(row)) next_cells[r*COLS + c] = 1'b1;
          OP_RCOL: if (c == int'(col)) next_cells[r*COLS + c] = 1'b1;
          OP_WR:   if (hit) next_cells[r*COLS + c] = wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xbar_store.sv
module xbar_store #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROWS*COLS-1:0] d,
  output logic [ROWS*COLS-1:0] q
);
  genvar gr;
  generate
    for (gr = 0; gr < ROWS; gr++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rst_n) q[gr*COLS +: COLS] <= '1;
        else        q[gr*COLS +: COLS] <= d[gr*COLS +: COLS];
      end
    end
  endgenerate

  // R1
  reset_ones_chk: assert property (@(posedge clk) !rst_n |=> q == '1);
endmodule

// File: rtl/nor_xbar.sv
module nor_xbar
  import xbar_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_op,
  input  logic [RW-1:0]        cmd_row,
  input  logic [CW-1:0]        cmd_col,
  input  logic [CW-1:0]        cmd_src,
  input  logic [COLS-1:0]      cmd_in_cols,
  input  logic [ROWS-1:0]      cmd_in_rows,
  input  logic [ROWS-1:0]      cmd_mask,
  input  logic                 cmd_wdata,
  output logic                 rd_data,
  output logic                 rd_valid,
  output logic                 err,
  output logic [ROWS*COLS-1:0] state
);
  xbar_op_e            op;
  logic [ROWS*COLS-1:0] next_cells;
  logic                tgt_zero;
  logic                logic_cmd;
  logic                read_cmd;
  logic                tgt_bit;

  assign op        = xbar_op_e'(cmd_op);
  assign logic_cmd = is_logic_op(op);
  assign read_cmd  = (op == OP_RD);
  assign tgt_bit   = state[int'(cmd_row)*COLS + int'(cmd_col)];

  xbar_eval #(.ROWS(ROWS), .COLS(COLS)) u_eval (
    .cells(state), .op(op), .row(cmd_row), .col(cmd_col), .src(cmd_src),
    .in_cols(cmd_in_cols), .in_rows(cmd_in_rows), .mask(cmd_mask),
    .wdata(cmd_wdata), .next_cells(next_cells), .tgt_zero(tgt_zero)
  );

  xbar_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk(clk), .rst_n(rst_n), .d(next_cells), .q(state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= 1'b0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= read_cmd;
      if (read_cmd) rd_data <= tgt_bit;
      err      <= logic_cmd & tgt_zero;
    end
  end

  // R5
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    logic_cmd |=> (state & ~$past(state)) == '0);
  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(logic_cmd));
  // R6
  err_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_NORV || op == OP_NOT) && !tgt_bit) |=> err);
  // R7
  row_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_RROW |=> state[int'($past(cmd_row))*COLS +: COLS] == '1);
  // R9
  read_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_cmd |=> rd_valid && rd_data == $past(tgt_bit) && $stable(state));
  // R9
  read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !read_cmd |=> !rd_valid);
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_IDLE |=> $stable(state) && !err);
endmodule

// File: tb/nor_xbar_test.sv
`timescale 1ns/1ps
module nor_xbar_test;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [RW-1:0] cmd_row = '0;
  logic [CW-1:0] cmd_col = '0, cmd_src = '0;
  logic [COLS-1:0] cmd_in_cols = '0;
  logic [ROWS-1:0] cmd_in_rows = '0, cmd_mask = '0;
  logic cmd_wdata = 1'b0;
  logic rd_data, rd_valid, err;
  logic [ROWS*COLS-1:0] state;

  int checks = 0;
  int errors = 0;
  bit refm [ROWS][COLS];

  always #4 clk = ~clk;

  nor_xbar #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_src(cmd_src), .cmd_in_cols(cmd_in_cols),
    .cmd_in_rows(cmd_in_rows), .cmd_mask(cmd_mask), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .err(err), .state(state)
  );

  task automatic check(input string tag, input string what,
                       input logic [ROWS*COLS-1:0] act, input logic [ROWS*COLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [ROWS*COLS-1:0] ref_flat();
    logic [ROWS*COLS-1:0] v;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        v[r*COLS + c] = refm[r][c];
    return v;
  endfunction

  task automatic issue(input int op, input int r, input int c, input int s,
                       input logic [COLS-1:0] ic, input logic [ROWS-1:0] ir,
                       input logic [ROWS-1:0] m, input logic wd, input string tag);
    bit old [ROWS][COLS];
    logic exp_err, exp_rv, exp_rd;
    old = refm;
    exp_err = 0; exp_rv = 0; exp_rd = 0;
    case (op)
      1: for (int rr = 0; rr < ROWS; rr++) if (m[rr]) begin
           bit any = 0;
           for (int cc = 0; cc < COLS; cc++) if (ic[cc] && old[rr][cc]) any = 1;
           if (!old[rr][c]) exp_err = 1;
           refm[rr][c] = old[rr][c] && !any;
         end
      2: begin
           bit any = 0;
           for (int rr = 0; rr < ROWS; rr++) if (ir[rr] && old[rr][c]) any = 1;
           if (!old[r][c]) exp_err = 1;
           refm[r][c] = old[r][c] && !any;
         end
      3: begin
           if (!old[r][c]) exp_err = 1;
           refm[r][c] = old[r][c] && !old[r][s];
         end
      4: for (int cc = 0; cc < COLS; cc++) refm[r][cc] = 1;
      5: for (int rr = 0; rr < ROWS; rr++) refm[rr][c] = 1;
      6: refm[r][c] = wd;
      7: begin exp_rv = 1; exp_rd = old[r][c]; end
      default: ;
    endcase
    @(negedge clk);
    cmd_op = op[2:0]; cmd_row = r[RW-1:0]; cmd_col = c[CW-1:0]; cmd_src = s[CW-1:0];
    cmd_in_cols = ic; cmd_in_rows = ir; cmd_mask = m; cmd_wdata = wd;
    @(posedge clk);
    #2;
    check(tag, "array", state, ref_flat());
    check("R6", "err", {{(ROWS*COLS-1){1'b0}}, err}, {{(ROWS*COLS-1){1'b0}}, exp_err});
    check("R9", "rd_valid", {{(ROWS*COLS-1){1'b0}}, rd_valid}, {{(ROWS*COLS-1){1'b0}}, exp_rv});
    if (exp_rv) check("R9", "rd_data", {{(ROWS*COLS-1){1'b0}}, rd_data}, {{(ROWS*COLS-1){1'b0}}, exp_rd});
    cmd_op = '0;
  endtask

  task automatic test_reset();
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) refm[r][c] = 1;
    check("R1", "state", state, '1);
    check("R1", "err", {{(ROWS*COLS-1){1'b0}}, err}, '0);
    check("R1", "rd_valid", {{(ROWS*COLS-1){1'b0}}, rd_valid}, '0);
    check("R1", "rd_data", {{(ROWS*COLS-1){1'b0}}, rd_data}, '0);
  endtask

  task automatic test_write_read();
    issue(6, 2, 5, 0, '0, '0, '0, 1'b0, "R8");
    issue(6, 7, 0, 0, '0, '0, '0, 1'b0, "R8");
    issue(7, 2, 5, 0, '0, '0, '0, 1'b0, "R9");
    issue(7, 3, 5, 0, '0, '0, '0, 1'b0, "R9");
    issue(0, 0, 0, 0, '0, '0, '0, 1'b0, "R10");
    issue(6, 2, 5, 0, '0, '0, '0, 1'b1, "R8");
  endtask

  task automatic test_row_nor();
    // inputs in columns 0 and 1, output column 3
    issue(6, 0, 0, 0, '0, '0, '0, 1'b0, "R8");
    issue(6, 0, 1, 0, '0, '0, '0, 1'b0, "R8");   // row 0: all inputs zero
    issue(6, 1, 0, 0, '0, '0, '0, 1'b0, "R8");   // row 1: one input one
    issue(4, 4, 0, 0, '0, '0, '0, 1'b0, "R7");
    issue(1, 0, 3, 0, 8'b0000_0011, '0, 8'b0001_0011, 1'b0, "R2");
    issue(1, 0, 5, 0, 8'b0000_0001, '0, 8'b1111_1111, 1'b0, "R2");
    issue(7, 0, 3, 0, '0, '0, '0, 1'b0, "R5");
  endtask

  task automatic test_col_nor_not();
    issue(5, 0, 6, 0, '0, '0, '0, 1'b0, "R7");
    issue(6, 1, 6, 0, '0, '0, '0, 1'b0, "R8");
    issue(6, 2, 6, 0, '0, '0, '0, 1'b0, "R8");
    issue(2, 5, 6, 0, '0, 8'b0000_0110, '0, 1'b0, "R3");  // inputs all zero
    issue(2, 6, 6, 0, '0, 8'b0000_0111, '0, 1'b0, "R3");  // one input one
    issue(3, 7, 2, 0, '0, '0, '0, 1'b0, "R4");            // input is 0 -> stays 1
    issue(3, 7, 4, 1, '0, '0, '0, 1'b0, "R4");            // input is 1 -> 0
  endtask

  task automatic test_errors();
    issue(3, 7, 4, 2, '0, '0, '0, 1'b0, "R6");            // target already 0
    issue(2, 6, 6, 0, '0, 8'b0000_0001, '0, 1'b0, "R6");
    issue(1, 0, 3, 0, 8'b0000_0100, '0, 8'b0000_0011, 1'b0, "R6");
    issue(4, 7, 0, 0, '0, '0, '0, 1'b0, "R7");
    issue(3, 7, 4, 2, '0, '0, '0, 1'b0, "R6");            // prepared, no error
  endtask

  task automatic test_random();
    for (int i = 0; i < 400; i++) begin
      int op, r, c, s;
      logic [COLS-1:0] ic;
      logic [ROWS-1:0] ir, m;
      op = int'($urandom_range(0, 7));
      r = int'($urandom_range(0, ROWS-1));
      c = int'($urandom_range(0, COLS-1));
      s = (c + 1 + int'($urandom_range(0, COLS-2))) % COLS;
      ic = COLS'($urandom) & ~(COLS'(1) << c);
      ir = ROWS'($urandom) & ~(ROWS'(1) << r);
      m = ROWS'($urandom);
      issue(op, r, c, s, ic, ir, m, 1'($urandom), op == 1 ? "R2" : op == 2 ? "R3" :
            op == 3 ? "R4" : op == 6 ? "R8" : op == 7 ? "R9" : op == 0 ? "R10" : "R7");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_write_read();
    test_row_nor();
    test_col_nor_not();
    test_errors();
    test_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule